// File: doc/BRIEF.md
# Sector Read Engine with Geometry Translation and Memory Write-Back

This block sits on the device side of a storage link. Software programs it through three word-wide registers: a flat block index, a byte address in main memory, and a control word. Setting the start bit in the control word launches one read. The engine splits the flat index into a cylinder position made of track, surface and sector-in-track, and presents that position together with a word index to a storage array that answers in the same cycle. After a fixed positioning delay, which stands in for head travel and platter rotation, it copies the whole sector word by word to main memory over a valid/ready write channel. No processor cycles are spent on the copy.

When the last word has been accepted, the engine raises its interrupt line and its done status together. Both stay high until software writes the acknowledge bit. The positioning delay is charged once per sector; every later word moves as soon as the memory side accepts it. Start commands that arrive while a transfer is running, and indices that point past the end of the media, are refused and set a sticky error flag.

Top module: `blkdma_read_engine`

## Requirements
- R1: After reset the status word reads zero, the interrupt is low, no memory write is offered, and the index and address registers read zero.
- R2: For a flat index N, with S sectors per track and H surfaces, the storage position is sector = N mod S, surface = (N div S) mod H, track = N div (S*H).
- R3: The first memory write is offered exactly ACCESS_LAT clock cycles after the edge that accepts the start command, and later words need no extra delay.
- R4: Word i of the sector (storage word index i, counting from 0) goes to byte address base + 4*i, carrying the storage data for that word. An offered word holds its address and data until it is accepted, and nothing is written beyond the sector's last word.
- R5: The interrupt and the done bit (status bit 1) rise on the same clock edge that accepts the final word, and the busy bit (status bit 0) falls on that edge. The interrupt never rises earlier.
- R6: Writing the control word (offset 0) with bit 1 set clears the done bit, the interrupt and the error bit (status bit 2).
- R7: While busy, a control write with bit 0 set sets the error bit and does not disturb the running transfer, and writes to the index (offset 1) or address (offset 2) registers are ignored.
- R8: A start command whose index is at or beyond S*H*T (T tracks) sets the error bit and starts nothing.
- R9: The two low bits of the address register always read as zero, whatever was written.
- R10: An accepted start clears a done bit and interrupt left over from the previous transfer, even without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset: 0 control/status, 1 flat index, 2 memory address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Transfer-complete interrupt, held until acknowledged |
| dma_valid | output | 1 | Memory write word offered |
| dma_ready | input | 1 | Memory side accepts the offered word |
| dma_addr | output | 32 | Byte address of the offered word |
| dma_data | output | 32 | Offered word |
| stor_surface | output | SURF_W | Storage surface select |
| stor_track | output | TRK_W | Storage track select |
| stor_sector | output | SECT_W | Storage sector-in-track select |
| stor_word | output | WORD_W | Word index inside the sector |
| stor_rdata | input | 32 | Storage word at the selected position, same cycle |

## Verification
The bench sweeps every flat index of a small media with a sector count per track that is not a power of two. This exposes a translation that uses bit slicing instead of division, because that would fetch data from the wrong storage position. For every transfer it times the delay from start to first offer and the edge on which the interrupt rises. An off-by-one in the positioning counter would show up as a shifted first offer, and a completion flag taken from the wrong cycle would raise the interrupt early or late. Back-pressure alternates between transfers, and the word just past each sector is checked against a sentinel, so a stride or end-of-sector fault leaves a visibly wrong or overwritten memory image. Separate scenarios issue a start while busy, a start with an index past the media end and an unaligned address, and look at the status, the retained registers and the memory image for a refused command that had any effect.

// File: rtl/blkdma_pkg.sv
// Shared definitions for the sector read engine: transfer states and the
// register map used by the software-facing register bank.
package blkdma_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_SEEK = 2'd1,
        XS_XFER = 2'd2
    } xfer_state_e;

    // Register word offsets
    localparam logic [1:0] OFS_CTRL = 2'd0;
    localparam logic [1:0] OFS_LBN  = 2'd1;
    localparam logic [1:0] OFS_DST  = 2'd2;

    // Control bits (write) and status bits (read) at OFS_CTRL
    localparam int CTL_START = 0;
    localparam int CTL_ACK   = 1;
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;

endpackage

// File: rtl/blkdma_geom_map.sv
// Translates a flat block index into a (track, surface, sector) position.
// Assumes all counts are constants; the divisions reduce to constant dividers.
module blkdma_geom_map #(
    parameter int SECT_PER_TRACK = 8,
    parameter int SURFACES       = 4,
    parameter int TRACKS         = 16,
    localparam int SECT_W = $clog2(SECT_PER_TRACK),
    localparam int SURF_W = $clog2(SURFACES),
    localparam int TRK_W  = $clog2(TRACKS)
) (
    input  logic [31:0]       lbn_i,
    output logic [SECT_W-1:0] sector_o,
    output logic [SURF_W-1:0] surface_o,
    output logic [TRK_W-1:0]  track_o,
    output logic              in_range_o
);
    localparam logic [31:0] SPT_U   = 32'(SECT_PER_TRACK);
    localparam logic [31:0] SURF_U  = 32'(SURFACES);
    localparam logic [31:0] CYL_U   = 32'(SECT_PER_TRACK * SURFACES);
    localparam logic [31:0] TOTAL_U = 32'(SECT_PER_TRACK * SURFACES * TRACKS);

    logic [31:0] per_track_q;

    // Mixed-radix split of the flat index.
    always_comb begin
        per_track_q = lbn_i / SPT_U;
        sector_o    = SECT_W'(lbn_i % SPT_U);
        surface_o   = SURF_W'(per_track_q % SURF_U);
        track_o     = TRK_W'(lbn_i / CYL_U);
        in_range_o  = (lbn_i < TOTAL_U);
    end

endmodule

// File: rtl/blkdma_regs.sv
// Software register bank: flat index, destination address, control/status.
// Assumes the transfer engine reports busy and a one-cycle finish strobe.
module blkdma_regs
    import blkdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy_i,
    input  logic        in_range_i,
    input  logic        finish_i,
    output logic        start_o,
    output logic [31:0] lbn_o,
    output logic [31:0] dst_o,
    output logic        err_o,
    output logic        irq_o
);
    logic cmd_wr, want_start, want_ack;
    logic done_q, err_q;
    logic [31:0] lbn_q, dst_q;

    // Decode control writes and decide whether a start is accepted.
    always_comb begin
        cmd_wr     = reg_wr_en && (reg_addr == OFS_CTRL);
        want_start = cmd_wr && reg_wdata[CTL_START];
        want_ack   = cmd_wr && reg_wdata[CTL_ACK];
        start_o    = want_start && !busy_i && in_range_i;
    end

    // Register storage with sticky done/error flags; later updates take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lbn_q  <= '0;
            dst_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (reg_wr_en && !busy_i && reg_addr == OFS_LBN)
                lbn_q <= reg_wdata;
            if (reg_wr_en && !busy_i && reg_addr == OFS_DST)
                dst_q <= {reg_wdata[31:2], 2'b00};
            if (want_ack) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (want_start && (busy_i || !in_range_i))
                err_q <= 1'b1;
            if (start_o)
                done_q <= 1'b0;
            if (finish_i)
                done_q <= 1'b1;
        end
    end

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[STAT_BUSY] = busy_i;
                reg_rdata[STAT_DONE] = done_q;
                reg_rdata[STAT_ERR]  = err_q;
            end
            OFS_LBN: reg_rdata = lbn_q;
            OFS_DST: reg_rdata = dst_q;
            default: reg_rdata = '0;
        endcase
    end

    assign lbn_o = lbn_q;
    assign dst_o = dst_q;
    assign err_o = err_q;
    assign irq_o = done_q;

endmodule

// File: rtl/blkdma_xfer.sv
// Transfer sequencer: waits a fixed positioning delay, then streams one
// sector from the storage port to the memory write channel.
// Assumes storage answers combinationally and ACCESS_LAT >= 1.
module blkdma_xfer
    import blkdma_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ACCESS_LAT   = 20,
    parameter int SECT_W       = 3,
    parameter int SURF_W       = 2,
    parameter int TRK_W        = 4,
    localparam int WORDS  = SECTOR_BYTES / 4,
    localparam int WORD_W = $clog2(WORDS),
    localparam int CNT_W  = $clog2(ACCESS_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SECT_W-1:0] sector_i,
    input  logic [SURF_W-1:0] surface_i,
    input  logic [TRK_W-1:0]  track_i,
    input  logic [31:0]       dst_i,
    output logic              busy_o,
    output logic              finish_o,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [31:0]       dma_addr,
    output logic [31:0]       dma_data,
    output logic [SECT_W-1:0] stor_sector,
    output logic [SURF_W-1:0] stor_surface,
    output logic [TRK_W-1:0]  stor_track,
    output logic [WORD_W-1:0] stor_word,
    input  logic [31:0]       stor_rdata
);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);
    localparam logic [CNT_W-1:0]  LAT_LOAD  = CNT_W'(ACCESS_LAT - 1);

    xfer_state_e        state_q;
    logic [CNT_W-1:0]   lat_q;
    logic [WORD_W-1:0]  word_q;
    logic [31:0]        addr_q;
    logic [SECT_W-1:0]  sect_q;
    logic [SURF_W-1:0]  surf_q;
    logic [TRK_W-1:0]   trk_q;

    // Sequencer: idle -> positioning delay -> word stream -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            lat_q   <= '0;
            word_q  <= '0;
            addr_q  <= '0;
            sect_q  <= '0;
            surf_q  <= '0;
            trk_q   <= '0;
        end else begin
            case (state_q)
                XS_IDLE: if (start_i) begin
                    sect_q  <= sector_i;
                    surf_q  <= surface_i;
                    trk_q   <= track_i;
                    addr_q  <= dst_i;
                    word_q  <= '0;
                    lat_q   <= LAT_LOAD;
                    state_q <= XS_SEEK;
                end
                XS_SEEK: begin
                    if (lat_q == '0) state_q <= XS_XFER;
                    else             lat_q   <= lat_q - 1'b1;
                end
                XS_XFER: if (dma_ready) begin
                    if (word_q == LAST_WORD) begin
                        state_q <= XS_IDLE;
                    end else begin
                        word_q <= word_q + 1'b1;
                        addr_q <= addr_q + 32'd4;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    // Port and status outputs.
    always_comb begin
        busy_o       = (state_q != XS_IDLE);
        dma_valid    = (state_q == XS_XFER);
        finish_o     = dma_valid && dma_ready && (word_q == LAST_WORD);
        dma_addr     = addr_q;
        dma_data     = stor_rdata;
        stor_sector  = sect_q;
        stor_surface = surf_q;
        stor_track   = trk_q;
        stor_word    = word_q;
    end

endmodule

// File: rtl/blkdma_read_engine.sv
// Top level of the sector read engine: register bank, geometry translation
// and transfer sequencer. Assumes a same-cycle storage array on the stor_* port.
module blkdma_read_engine #(
    parameter int SECTOR_BYTES   = 512,
    parameter int SECT_PER_TRACK = 8,
    parameter int SURFACES       = 4,
    parameter int TRACKS         = 16,
    parameter int ACCESS_LAT     = 20,
    localparam int SECT_W = $clog2(SECT_PER_TRACK),
    localparam int SURF_W = $clog2(SURFACES),
    localparam int TRK_W  = $clog2(TRACKS),
    localparam int WORD_W = $clog2(SECTOR_BYTES / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic [31:0]       dma_addr,
    output logic [31:0]       dma_data,
    output logic [SURF_W-1:0] stor_surface,
    output logic [TRK_W-1:0]  stor_track,
    output logic [SECT_W-1:0] stor_sector,
    output logic [WORD_W-1:0] stor_word,
    input  logic [31:0]       stor_rdata
);
    logic              xfer_busy, xfer_finish, start_go, lbn_ok, err_flag;
    logic [31:0]       lbn_val, dst_val;
    logic [SECT_W-1:0] map_sector;
    logic [SURF_W-1:0] map_surface;
    logic [TRK_W-1:0]  map_track;

    blkdma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (xfer_busy),
        .in_range_i (lbn_ok),
        .finish_i   (xfer_finish),
        .start_o    (start_go),
        .lbn_o      (lbn_val),
        .dst_o      (dst_val),
        .err_o      (err_flag),
        .irq_o      (irq)
    );

    blkdma_geom_map #(
        .SECT_PER_TRACK (SECT_PER_TRACK),
        .SURFACES       (SURFACES),
        .TRACKS         (TRACKS)
    ) u_geom (
        .lbn_i      (lbn_val),
        .sector_o   (map_sector),
        .surface_o  (map_surface),
        .track_o    (map_track),
        .in_range_o (lbn_ok)
    );

    blkdma_xfer #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .ACCESS_LAT   (ACCESS_LAT),
        .SECT_W       (SECT_W),
        .SURF_W       (SURF_W),
        .TRK_W        (TRK_W)
    ) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_go),
        .sector_i     (map_sector),
        .surface_i    (map_surface),
        .track_i      (map_track),
        .dst_i        (dst_val),
        .busy_o       (xfer_busy),
        .finish_o     (xfer_finish),
        .dma_valid    (dma_valid),
        .dma_ready    (dma_ready),
        .dma_addr     (dma_addr),
        .dma_data     (dma_data),
        .stor_sector  (stor_sector),
        .stor_surface (stor_surface),
        .stor_track   (stor_track),
        .stor_word    (stor_word),
        .stor_rdata   (stor_rdata)
    );

endmodule

// File: rtl/blkdma_read_engine_chk.sv
// Protocol and status checks for the sector read engine, bound to the top.
module blkdma_read_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        err,
    input logic        irq,
    input logic        reg_wr_en,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        dma_valid,
    input logic        dma_ready,
    input logic [31:0] dma_addr,
    input logic [31:0] dma_data
);
    logic cmd_start;
    assign cmd_start = reg_wr_en && (reg_addr == 2'd0) && reg_wdata[0];

    // R4: a stalled word keeps its address and data
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_data));

    // R4: consecutive words step by four bytes
    assert_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && dma_ready |=> !dma_valid || (dma_addr == $past(dma_addr) + 32'd4));

    // R4: words are only offered during a transfer
    assert_valid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> busy);

    // R5: the interrupt rises only as the transfer ends
    assert_irq_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    // R7: a start during a transfer flags an error
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_start |=> err);

    // R10: no stale interrupt while a transfer runs
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq);

endmodule

bind blkdma_read_engine blkdma_read_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (xfer_busy),
    .err       (err_flag),
    .irq       (irq),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dma_valid (dma_valid),
    .dma_ready (dma_ready),
    .dma_addr  (dma_addr),
    .dma_data  (dma_data)
);

// File: tb/blkdma_read_engine_tb.sv
`timescale 1ns/1ps
// Sweeps every block of a small media image and checks memory contents,
// timing of the first word and of the interrupt, and refused commands.
module blkdma_read_engine_tb;
    localparam int SB    = 64;
    localparam int SPT   = 3;
    localparam int SURF  = 2;
    localparam int TRK   = 4;
    localparam int LAT   = 5;
    localparam int WORDS = SB / 4;
    localparam int TOTAL = SPT * SURF * TRK;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, dma_valid, dma_addr_unused;
    logic        dma_ready = 1'b1;
    logic [31:0] dma_addr, dma_data, stor_rdata;
    logic [0:0]  stor_surface;
    logic [1:0]  stor_track, stor_sector;
    logic [3:0]  stor_word;

    int checks = 0;
    int errors = 0;
    int hs_cnt = 0;
    logic hs_clr = 1'b0;
    logic stall_mode = 1'b0;
    int rdy_cnt = 0;
    logic [31:0] mem [0:511];

    always #2.5 clk = ~clk;

    blkdma_read_engine #(
        .SECTOR_BYTES(SB), .SECT_PER_TRACK(SPT), .SURFACES(SURF),
        .TRACKS(TRK), .ACCESS_LAT(LAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
        .dma_data(dma_data), .stor_surface(stor_surface), .stor_track(stor_track),
        .stor_sector(stor_sector), .stor_word(stor_word), .stor_rdata(stor_rdata)
    );

    assign dma_addr_unused = 1'b0;

    // Storage image: each word encodes its own position.
    assign stor_rdata = {4'hC, 4'(stor_surface), 8'(stor_track), 8'(stor_sector), 8'(stor_word)};

    // Main-memory model and handshake counter.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 512; k++) mem[k] <= SENT;
        end else if (dma_valid && dma_ready) begin
            mem[dma_addr[10:2]] <= dma_data;
        end
        if (hs_clr) hs_cnt <= 0;
        else if (rst_n && dma_valid && dma_ready) hs_cnt <= hs_cnt + 1;
    end

    // Back-pressure pattern.
    always @(negedge clk) begin
        dma_ready <= stall_mode ? (rdy_cnt % 3 != 2) : 1'b1;
        rdy_cnt   <= rdy_cnt + 1;
    end

    function automatic logic [31:0] exp_word(int lbn, int w);
        int sect, surf, trk;
        sect = lbn % SPT;
        surf = (lbn / SPT) % SURF;
        trk  = lbn / (SPT * SURF);
        return 32'hC000_0000 | 32'(surf << 24) | 32'(trk << 16) | 32'(sect << 8) | 32'(w);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clear_hs();
        hs_clr = 1'b1;
        @(negedge clk);
        hs_clr = 1'b0;
    endtask

    // Waits for the last word; checks the interrupt edge and status (R5).
    task automatic wait_done();
        logic early;
        logic [31:0] st;
        early = 1'b0;
        while (hs_cnt < WORDS) begin
            if (irq) early = 1'b1;
            @(negedge clk);
        end
        check("R5 irq not early", 32'(early), 32'd0);
        check("R5 irq at last word", 32'(irq), 32'd1);
        reg_read(2'd0, st);
        check("R5 status done, not busy", st & 32'h3, 32'h2);
    endtask

    task automatic check_mem(int lbn, logic [31:0] dst, logic tail);
        for (int w = 0; w < WORDS; w++)
            check("R2/R4 sector word", mem[dst[10:2] + 9'(w)], exp_word(lbn, w));
        if (tail) check("R4 no overrun", mem[dst[10:2] + 9'(WORDS)], SENT);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] st, dst;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        reg_read(2'd0, st); check("R1 status", st, 32'd0);
        reg_read(2'd1, st); check("R1 index", st, 32'd0);
        reg_read(2'd2, st); check("R1 address", st, 32'd0);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 valid", 32'(dma_valid), 32'd0);

        // R2 R3 R4 R5 R6 R10: sweep every block
        for (int i = 0; i < TOTAL; i++) begin
            stall_mode = i[0];
            dst = 32'(i * SB);
            reg_write(2'd1, 32'(i));
            reg_write(2'd2, dst);
            clear_hs();
            reg_write(2'd0, 32'h1);
            if (i % 2 == 0 && i > 0) begin
                check("R10 irq cleared by start", 32'(irq), 32'd0);
                reg_read(2'd0, st);
                check("R10 status busy only", st, 32'h1);
            end
            cyc = 0;
            while (!dma_valid) begin
                @(negedge clk);
                cyc++;
            end
            check("R3 first word latency", 32'(cyc), 32'(LAT));
            wait_done();
            check_mem(i, dst, i < TOTAL - 1);
            if (i % 2 == 0) begin
                reg_write(2'd0, 32'h2);
                reg_read(2'd0, st);
                check("R6 ack clears status", st, 32'd0);
                check("R6 ack clears irq", 32'(irq), 32'd0);
            end
        end
        reg_write(2'd0, 32'h2);

        // R8: index past media end
        clear_hs();
        reg_write(2'd1, 32'(TOTAL));
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, st);
        check("R8 error, not busy", st, 32'h4);
        repeat (LAT + 4) @(negedge clk);
        check("R8 nothing written", 32'(hs_cnt), 32'd0);
        reg_write(2'd0, 32'h2);
        reg_read(2'd0, st);
        check("R6 ack clears error", st, 32'd0);

        // R9: unaligned address
        reg_write(2'd2, 32'h0000_0603);
        reg_read(2'd2, st);
        check("R9 low bits zero", st, 32'h0000_0600);

        // R7: commands while busy
        stall_mode = 1'b1;
        reg_write(2'd1, 32'd7);
        clear_hs();
        reg_write(2'd0, 32'h1);
        reg_write(2'd1, 32'd3);
        reg_write(2'd2, 32'h0000_0100);
        reg_write(2'd0, 32'h1);
        reg_read(2'd0, st);
        check("R7 busy with error", st & 32'h5, 32'h5);
        reg_read(2'd1, st);
        check("R7 index kept", st, 32'd7);
        reg_read(2'd2, st);
        check("R7 address kept", st, 32'h0000_0600);
        wait_done();
        check_mem(7, 32'h0000_0600, 1'b1);
        reg_read(2'd0, st);
        check("R7 error still set", st, 32'h6);
        check("R7 no second transfer", 32'(hs_cnt), 32'(WORDS));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule